// File: doc/BRIEF.md
# Dual-Mode Timer/Counter Pair

This block holds two 16-bit timer/counters of the classic 8-bit microcontroller kind. Each unit is made of a low count byte and a high count byte. It advances either once per clock (timer use) or once per falling edge seen on its own external count pin (counter use). A mode register selects how each unit counts. The choices are a 13-bit count with a 5-bit prescaler, a plain 16-bit count, an 8-bit count that reloads itself from the high byte, and a fourth mode. In the fourth mode timer 1 freezes and timer 0 splits into two independent 8-bit counters.

Software reaches the block through a byte-wide write port with address decode. That port covers a control register, the mode register and the four count bytes. All of these are visible continuously on output ports. Each unit can be held off by a run bit. Optionally it can also be held off by an external gate pin. A counter that wraps sets a sticky overflow flag in the control register, which software clears by writing 0.

Top module: `tmr_pair`

## Requirements
- R1: A synchronous active-high reset clears the control register, the mode register, all four count bytes and both overflow flags to 0, and leaves both edge samplers at a high level.
- R2: Writes land on the next clock edge at these addresses: 0x88 control, 0x89 mode, 0x8A unit-0 low byte, 0x8B unit-1 low byte, 0x8C unit-0 high byte, 0x8D unit-1 high byte. A write to a count byte replaces that byte and suppresses any increment of that byte in the same cycle.
- R3: With mode field 01, both counts form a 16-bit counter (high:low) that advances once per enabled tick. Wrapping from 0xFFFF to 0x0000 sets the unit's flag: control bit 5 for unit 0, bit 7 for unit 1.
- R4: Mode register layout: unit 0 uses bits 3:0 and unit 1 uses bits 7:4. Within each nibble, bit 3 is gate, bit 2 selects the external source, and bits 1:0 are the mode field. Run bits are control bit 4 (unit 0) and bit 6 (unit 1). A unit is enabled when its run bit is 1 and either its gate bit is 0 or its gate pin is high. A disabled unit keeps its count.
- R5: With the source select at 1, a unit ticks once for each pair of consecutive clock samples of its count pin that read high then low. A pin held low counts once, a rising edge does not count, and a pin high through reset gives no count.
- R6: With mode field 00, low-byte bits 4:0 form a prescaler that advances per tick. The high byte advances when the prescaler wraps from 31. Low-byte bits 7:5 never change.
- R7: With mode field 10, the low byte advances per tick. On a tick at 0xFF it takes the high byte's value instead and sets the unit's flag. The high byte is unchanged.
- R8: With mode field 11, unit 1 holds both count bytes whatever its run bit.
- R9: With unit 0 in mode field 11, its low byte is an 8-bit counter under unit 0's run, gate and source controls, and it sets control bit 5 on wrap. Its high byte advances every clock while control bit 6 is 1 and sets control bit 7 on wrap.
- R10: Flags stay at 1 until a control write puts 0 there. When hardware sets a flag in the same cycle that software writes 0 to it, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| ext_count_in | input | 2 | External count pins, bit n for unit n |
| ext_gate_in | input | 2 | External gate pins, bit n for unit n |
| ctrl_q | output | 8 | Control register contents (run bits and flags) |
| mode_q | output | 8 | Mode register contents |
| count0_q | output | 16 | Unit 0 count, high byte over low byte |
| count1_q | output | 16 | Unit 1 count, high byte over low byte |
| ovf_flag | output | 2 | Overflow flags, bit n for unit n |

## Verification
Two pairs of functions can meet in one cycle. A software write to a count byte can coincide with the increment of that same byte. A software write of 0 to a flag can coincide with a hardware overflow that sets it. The bench provokes the first by writing a low byte while its unit is running. It then expects exactly the written value, with no increment on top. It provokes the second by arranging an auto-reload unit so that the clearing write to the control register falls on the clock where the low byte wraps, and it expects the flag to read 1 and the reload value to appear.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

    localparam int BYTE_W    = 8;
    localparam int PRESC_W   = 5;
    localparam int ADDR_W    = 8;
    localparam int NUM_UNITS = 2;
    localparam int CFG_W     = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h88;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 8'h89;
    localparam logic [ADDR_W-1:0] ADDR_LO0  = 8'h8A;
    localparam logic [ADDR_W-1:0] ADDR_HI0  = 8'h8C;

    typedef enum logic [1:0] {
        MODE_PRESC  = 2'b00,
        MODE_WIDE   = 2'b01,
        MODE_RELOAD = 2'b10,
        MODE_SPLIT  = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic      gate;
        logic      ext_sel;
        tmr_mode_e mode;
    } unit_cfg_t;

    function automatic unit_cfg_t cfg_of(input logic [BYTE_W-1:0] mreg, input int unsigned u);
        return unit_cfg_t'(mreg[u*CFG_W +: CFG_W]);
    endfunction

    function automatic int unsigned run_bit(input int unsigned u);
        return 4 + 2 * u;
    endfunction

    function automatic int unsigned flag_bit(input int unsigned u);
        return 5 + 2 * u;
    endfunction

endpackage

// File: rtl/tmr_fall_det.sv
module tmr_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic [1:0] samp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 2'b11;
        end else begin
            samp_q <= {samp_q[0], pin};
        end
    end

    // older sample high, newer sample low
    assign fall = samp_q[1] & ~samp_q[0];

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pair_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int PRESC_W  = 5,
    parameter bit SPLIT_OK = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  tmr_mode_e         mode,
    input  logic              tick,
    input  logic              tick_hi,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q,
    output logic              ovf,
    output logic              ovf_hi
);
    localparam logic [BYTE_W-1:0]  ONES   = '1;
    localparam logic [PRESC_W-1:0] P_ONES = '1;

    logic [BYTE_W-1:0] lo_n, hi_n;

    always_comb begin
        lo_n   = lo_q;
        hi_n   = hi_q;
        ovf    = 1'b0;
        ovf_hi = 1'b0;
        case (mode)
            MODE_PRESC: begin
                if (tick) begin
                    lo_n[PRESC_W-1:0] = lo_q[PRESC_W-1:0] + 1'b1;
                    if (lo_q[PRESC_W-1:0] == P_ONES) begin
                        hi_n = hi_q + 1'b1;
                        ovf  = (hi_q == ONES);
                    end
                end
            end
            MODE_WIDE: begin
                if (tick) begin
                    {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
                    ovf = (lo_q == ONES) && (hi_q == ONES);
                end
            end
            MODE_RELOAD: begin
                if (tick) begin
                    if (lo_q == ONES) begin
                        lo_n = hi_q;
                        ovf  = 1'b1;
                    end else begin
                        lo_n = lo_q + 1'b1;
                    end
                end
            end
            MODE_SPLIT: begin
                if (SPLIT_OK) begin
                    if (tick) begin
                        lo_n = lo_q + 1'b1;
                        ovf  = (lo_q == ONES);
                    end
                    if (tick_hi) begin
                        hi_n   = hi_q + 1'b1;
                        ovf_hi = (hi_q == ONES);
                    end
                end
            end
            default: ;
        endcase
        // software write beats the increment of the same byte
        if (wr_lo) lo_n = wdata;
        if (wr_hi) hi_n = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pair_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic [NUM_UNITS-1:0]   ext_count_in,
    input  logic [NUM_UNITS-1:0]   ext_gate_in,
    output logic [BYTE_W-1:0]      ctrl_q,
    output logic [BYTE_W-1:0]      mode_q,
    output logic [2*BYTE_W-1:0]    count0_q,
    output logic [2*BYTE_W-1:0]    count1_q,
    output logic [NUM_UNITS-1:0]   ovf_flag
);
    logic [BYTE_W-1:0]    ctrl_r, ctrl_n, mode_r;
    logic [BYTE_W-1:0]    lo_v [NUM_UNITS];
    logic [BYTE_W-1:0]    hi_v [NUM_UNITS];
    logic [NUM_UNITS-1:0] ovf_main, ovf_split;
    logic [NUM_UNITS-1:0] flag_set;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        unit_cfg_t cfg;
        logic      enable, fall, tick, tick_hi, wr_lo, wr_hi;

        assign cfg    = cfg_of(mode_r, u);
        assign enable = ctrl_r[run_bit(u)] & (~cfg.gate | ext_gate_in[u]);

        tmr_fall_det u_fall (
            .clk  (clk),
            .rst  (rst),
            .pin  (ext_count_in[u]),
            .fall (fall)
        );

        assign tick  = enable & (cfg.ext_sel ? fall : 1'b1);
        assign wr_lo = wr_en && (wr_addr == ADDR_LO0 + ADDR_W'(u));
        assign wr_hi = wr_en && (wr_addr == ADDR_HI0 + ADDR_W'(u));

        if (u == 0) begin : g_split_hi
            // split high byte is timer-only, run by the neighbour's run bit
            assign tick_hi = ctrl_r[run_bit(1)];
        end else begin : g_no_split
            assign tick_hi = 1'b0;
        end

        tmr_counter #(
            .BYTE_W   (BYTE_W),
            .PRESC_W  (PRESC_W),
            .SPLIT_OK (u == 0)
        ) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .mode    (cfg.mode),
            .tick    (tick),
            .tick_hi (tick_hi),
            .wr_lo   (wr_lo),
            .wr_hi   (wr_hi),
            .wdata   (wr_data),
            .lo_q    (lo_v[u]),
            .hi_q    (hi_v[u]),
            .ovf     (ovf_main[u]),
            .ovf_hi  (ovf_split[u])
        );
    end

    // split high byte of unit 0 reports through unit 1's flag
    assign flag_set[0] = ovf_main[0];
    assign flag_set[1] = ovf_main[1] | (|ovf_split);

    always_comb begin
        ctrl_n = ctrl_r;
        if (wr_en && wr_addr == ADDR_CTRL) ctrl_n = wr_data;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (flag_set[u]) ctrl_n[flag_bit(u)] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r <= '0;
            mode_r <= '0;
        end else begin
            ctrl_r <= ctrl_n;
            if (wr_en && wr_addr == ADDR_MODE) mode_r <= wr_data;
        end
    end

    assign ctrl_q   = ctrl_r;
    assign mode_q   = mode_r;
    assign count0_q = {hi_v[0], lo_v[0]};
    assign count1_q = {hi_v[1], lo_v[1]};
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_flag_out
        assign ovf_flag[u] = ctrl_r[flag_bit(u)];
    end

endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
    import tmr_pair_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [BYTE_W-1:0]   wr_data,
    input logic [NUM_UNITS-1:0] ext_count_in,
    input logic [NUM_UNITS-1:0] ext_gate_in,
    input logic [BYTE_W-1:0]   ctrl_q,
    input logic [BYTE_W-1:0]   mode_q,
    input logic [2*BYTE_W-1:0] count0_q,
    input logic [2*BYTE_W-1:0] count1_q,
    input logic [NUM_UNITS-1:0] ovf_flag
);
    logic wr_ctrl, wr_lo0, wr_c0, wr_c1, pins_seen;

    assign wr_ctrl = wr_en && wr_addr == ADDR_CTRL;
    assign wr_lo0  = wr_en && wr_addr == ADDR_LO0;
    assign wr_c0   = wr_en && (wr_addr == ADDR_LO0 || wr_addr == ADDR_HI0);
    assign wr_c1   = wr_en && (wr_addr == ADDR_LO0 + 8'd1 || wr_addr == ADDR_HI0 + 8'd1);
    assign pins_seen = ^ext_count_in | 1'b1;

    assert_flag0_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        ovf_flag[0] && !wr_ctrl |=> ovf_flag[0]);

    assert_flag1_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        ovf_flag[1] && !wr_ctrl |=> ovf_flag[1]);

    assert_write_wins_R2: assert property (@(posedge clk) disable iff (rst)
        wr_lo0 |=> count0_q[7:0] == $past(wr_data));

    assert_unit1_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        mode_q[5:4] == 2'b11 && !wr_c1 |=> $stable(count1_q));

    assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[4] && mode_q[1:0] != 2'b11 && !wr_c0 |=> $stable(count0_q));

    assert_gate_block_R4: assert property (@(posedge clk) disable iff (rst)
        mode_q[3] && !ext_gate_in[0] && mode_q[1:0] != 2'b11 && !wr_c0 |=> $stable(count0_q));

    assert_wide_step_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[4] && mode_q[3:0] == 4'b0001 && !wr_c0 && pins_seen
        |=> count0_q == $past(count0_q) + 16'd1);

    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[6] && mode_q[7:4] == 4'b0010 && count1_q[7:0] == 8'hFF && !wr_c1
        |=> count1_q[7:0] == $past(count1_q[15:8]) && ovf_flag[1]);

    assert_presc_upper_R6: assert property (@(posedge clk) disable iff (rst)
        mode_q[1:0] == 2'b00 && !wr_lo0 |=> count0_q[7:5] == $past(count0_q[7:5]));

endmodule

bind tmr_pair tmr_pair_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .ext_count_in (ext_count_in),
    .ext_gate_in  (ext_gate_in),
    .ctrl_q       (ctrl_q),
    .mode_q       (mode_q),
    .count0_q     (count0_q),
    .count1_q     (count1_q),
    .ovf_flag     (ovf_flag)
);

// File: tb/tmr_pair_test.sv
module tmr_pair_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic [1:0]  ext_count_in = 2'b11;
    logic [1:0]  ext_gate_in = 2'b00;
    logic [7:0]  ctrl_q, mode_q;
    logic [15:0] count0_q, count1_q;
    logic [1:0]  ovf_flag;

    int applied = 0;
    int miscompares = 0;

    tmr_pair uut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .ext_count_in (ext_count_in),
        .ext_gate_in  (ext_gate_in),
        .ctrl_q       (ctrl_q),
        .mode_q       (mode_q),
        .count0_q     (count0_q),
        .count1_q     (count1_q),
        .ovf_flag     (ovf_flag)
    );

    always #4 clk = ~clk;

    localparam logic [1:0] SEL_C0 = 2'd0, SEL_C1 = 2'd1, SEL_CTRL = 2'd2;

    typedef struct packed {
        logic        do_wr;
        logic [7:0]  addr;
        logic [7:0]  data;
        logic [7:0]  idle;
        logic [1:0]  sel;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h8A, 8'hF0, 8'd0,  SEL_C0,   16'h00F0, 4'd2},  // R2 low byte write
        '{1'b1, 8'h8C, 8'hFF, 8'd0,  SEL_C0,   16'hFFF0, 4'd2},  // R2 high byte write
        '{1'b1, 8'h89, 8'h01, 8'd0,  SEL_C0,   16'hFFF0, 4'd4},  // R4 run bit off
        '{1'b1, 8'h88, 8'h10, 8'd15, SEL_C0,   16'hFFFF, 4'd3},  // R3 16-bit count
        '{1'b0, 8'h00, 8'h00, 8'd1,  SEL_C0,   16'h0000, 4'd3},  // R3 wrap
        '{1'b0, 8'h00, 8'h00, 8'd0,  SEL_CTRL, 16'h0030, 4'd3},  // R3 flag bit 5
        '{1'b1, 8'h88, 8'h10, 8'd0,  SEL_CTRL, 16'h0010, 4'd10}, // R10 clear by write
        '{1'b1, 8'h88, 8'h00, 8'd5,  SEL_C0,   16'h0002, 4'd4},  // R4 stop holds
        '{1'b1, 8'h89, 8'h00, 8'd0,  SEL_C0,   16'h0002, 4'd4},  // R4 still stopped
        '{1'b1, 8'h8A, 8'hFE, 8'd0,  SEL_C0,   16'h00FE, 4'd2},  // R2
        '{1'b1, 8'h8C, 8'h7F, 8'd0,  SEL_C0,   16'h7FFE, 4'd2},  // R2
        '{1'b1, 8'h88, 8'h10, 8'd2,  SEL_C0,   16'h80E0, 4'd6},  // R6 prescaler carry
        '{1'b1, 8'h88, 8'h00, 8'd0,  SEL_C0,   16'h80E1, 4'd6},  // R6 upper bits kept
        '{1'b1, 8'h89, 8'h20, 8'd0,  SEL_C1,   16'h0000, 4'd2},  // R2 mode write
        '{1'b1, 8'h8D, 8'hA0, 8'd0,  SEL_C1,   16'hA000, 4'd2},  // R2
        '{1'b1, 8'h8B, 8'hFD, 8'd0,  SEL_C1,   16'hA0FD, 4'd2},  // R2
        '{1'b1, 8'h88, 8'h40, 8'd3,  SEL_C1,   16'hA0A0, 4'd7},  // R7 reload
        '{1'b0, 8'h00, 8'h00, 8'd0,  SEL_CTRL, 16'h00C0, 4'd7},  // R7 flag bit 7
        '{1'b0, 8'h00, 8'h00, 8'd2,  SEL_C1,   16'hA0A2, 4'd7},  // R7 after reload
        '{1'b1, 8'h88, 8'h00, 8'd0,  SEL_C1,   16'hA0A3, 4'd7},  // R7
        '{1'b1, 8'h89, 8'h33, 8'd0,  SEL_C1,   16'hA0A3, 4'd8},  // R8
        '{1'b1, 8'h8A, 8'hFF, 8'd0,  SEL_C0,   16'h80FF, 4'd2},  // R2
        '{1'b1, 8'h8C, 8'hFE, 8'd0,  SEL_C0,   16'hFEFF, 4'd2},  // R2
        '{1'b1, 8'h88, 8'h50, 8'd2,  SEL_C0,   16'h0001, 4'd9},  // R9 split wraps
        '{1'b0, 8'h00, 8'h00, 8'd0,  SEL_CTRL, 16'h00F0, 4'd9},  // R9 both flags
        '{1'b1, 8'h88, 8'h00, 8'd0,  SEL_C0,   16'h0102, 4'd9},  // R9
        '{1'b0, 8'h00, 8'h00, 8'd0,  SEL_C1,   16'hA0A3, 4'd8},  // R8 frozen with run set
        '{1'b1, 8'h88, 8'h40, 8'd3,  SEL_C0,   16'h0402, 4'd9},  // R9 high byte on bit 6
        '{1'b1, 8'h88, 8'h00, 8'd0,  SEL_C0,   16'h0502, 4'd9},  // R9
        '{1'b0, 8'h00, 8'h00, 8'd0,  SEL_CTRL, 16'h0000, 4'd10}  // R10 cleared stays 0
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1", {ctrl_q, mode_q}, 16'h0000);
        check("R1", count0_q, 16'h0000);
        check("R1", count1_q, 16'h0000);
        check("R1", {14'd0, ovf_flag}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [15:0] act;
            if (VECS[i].do_wr) do_write(VECS[i].addr, VECS[i].data);
            wait_cycles(int'(VECS[i].idle));
            case (VECS[i].sel)
                SEL_C0:   act = count0_q;
                SEL_C1:   act = count1_q;
                default:  act = {8'h00, ctrl_q};
            endcase
            check($sformatf("R%0d vector %0d", VECS[i].req, i), act, VECS[i].exp);
        end

        // R1 reset from a non-zero state
        do_reset();
        check("R1", count0_q, 16'h0000);
        check("R1", {ctrl_q, mode_q}, 16'h0000);

        // R5 falling-edge counting at the maximum rate
        do_write(8'h89, 8'h05);
        do_write(8'h88, 8'h10);
        for (int p = 0; p < 5; p++) begin
            ext_count_in[0] = 1'b0;
            @(negedge clk);
            ext_count_in[0] = 1'b1;
            @(negedge clk);
        end
        wait_cycles(3);
        check("R5", count0_q, 16'h0005);
        ext_count_in[0] = 1'b0;
        wait_cycles(10);
        check("R5", count0_q, 16'h0006);
        ext_count_in[0] = 1'b1;
        wait_cycles(3);
        check("R5", count0_q, 16'h0006);

        // R4 gate pin
        do_reset();
        do_write(8'h89, 8'h09);
        do_write(8'h88, 8'h10);
        wait_cycles(10);
        check("R4", count0_q, 16'h0000);
        ext_gate_in[0] = 1'b1;
        wait_cycles(7);
        ext_gate_in[0] = 1'b0;
        check("R4", count0_q, 16'h0007);
        wait_cycles(3);
        check("R4", count0_q, 16'h0007);

        // R10 flag clear colliding with a reload overflow
        do_reset();
        do_write(8'h89, 8'h20);
        do_write(8'h8D, 8'h10);
        do_write(8'h8B, 8'hFE);
        do_write(8'h88, 8'h40);
        wait_cycles(1);
        do_write(8'h88, 8'h40);
        check("R10", {8'h00, ctrl_q}, 16'h00C0);
        check("R7", count1_q, 16'h1010);
        // R2 write to a running low byte: no increment on top
        do_write(8'h8B, 8'h55);
        check("R2", count1_q, 16'h1055);

        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule